// File: doc/BRIEF.md
# Broadcast-Form Fixed-Point FIR Filter

This block is a 25-tap finite impulse response filter. Every output is the weighted sum of the current input sample and the 24 before it, using coefficients fixed when the block is compiled. The structure is the transposed (broadcast) arrangement. The registered input sample goes to every coefficient multiplier at the same time. Each product is added to the running sum held in the register of the next tap further from the output. The longest path between registers is therefore one multiply and one add, whatever the tap count.

Input samples and coefficients are signed, with one sign bit and 15 fractional bits. Output samples are signed, with two integer bits and 15 fractional bits. Products keep full precision, and the partial sums carry extra guard bits so that they cannot overflow. Only the final sum is rounded and clamped to the output range. The block takes a new sample on every clock edge with no handshake. An asynchronous active-high reset clears all stored state.

Top module: `tfir_core`

## Requirements
- R1: While `arst` is high, `y_out` is 0 at once, with no clock edge needed. After reset is released, `y_out` stays 0 until a non-zero input has reached the output.
- R2: A sample present on `x_in` at clock edge e first affects `y_out` just after edge e+1. That is two register stages: the input register, then the output register.
- R3: The default coefficients are b_k = s_k * 2000 * m_k. Here m_k = k+1 for k <= 12 and m_k = 25-k otherwise, and s_k = -1 when k mod 4 = 3 and +1 otherwise. A single non-zero input v followed by zeros produces round(b_k * v / 2^15) on 25 consecutive cycles, for k = 0 to 24.
- R4: For any input sequence, the value of `y_out` after edge e+1 equals the rounded and clamped sum over k = 0..24 of b_k * x(e-k). Here x(j) is the value sampled at edge j, both operands are read as two's-complement Q1.15, and the result is Q2.15.
- R5: Rounding is round half up. The exact sum, in units of 2^-30, has 2^14 added to it and is then shifted right by 15 bits with sign extension.
- R6: A rounded result above 65535 gives `y_out` = 17'h0FFFF. A result below -65536 gives 17'h10000.
- R7: Partial sums inside the chain carry at least ceil(log2(25)) guard bits above the 32-bit product. Full-scale inputs of either sign therefore give the mathematically correct clamped result and never a wrapped one.
- R8: A new sample is accepted on every clock edge. A constant input held for at least 26 edges gives a constant output, equal to the clamped and rounded value of (sum of b_k) * x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| arst | input | 1 | Asynchronous active-high reset of all registers |
| x_in | input | 16 | Input sample, signed Q1.15 |
| y_out | output | 17 | Filtered output, signed Q2.15, registered |

## Verification
A wrong partial sum in any chain register reaches `y_out` after as many cycles as that register is away from the output tap, one to 24 cycles. It stays visible for exactly one output sample, so an impulse exposes a faulty tap at the position of that tap's coefficient. A missing input register or an extra pipeline stage moves the whole response by one cycle and shows on the first non-zero output. A fault in rounding or clamping shows only for particular sums, which is why low-amplitude impulses and full-scale steps of both signs are driven. If the reset does not act asynchronously, `y_out` fails to read zero within the cycle in which reset is raised.

// File: rtl/tfir_pkg.sv
`timescale 1ns/1ps
package tfir_pkg;
   localparam int TAPS_DEF = 25;
   localparam int CW_DEF   = 16;

   // Symmetric triangle of magnitudes, every fourth weight negated.
   function automatic logic [TAPS_DEF*CW_DEF-1:0] default_coef_vec();
      logic [TAPS_DEF*CW_DEF-1:0] v;
      int mag;
      v = '0;
      for (int k = 0; k < TAPS_DEF; k++) begin
         mag = (k <= TAPS_DEF/2) ? 2000*(k+1) : 2000*(TAPS_DEF-k);
         if (k % 4 == 3) mag = -mag;
         v[k*CW_DEF +: CW_DEF] = CW_DEF'(mag);
      end
      return v;
   endfunction
endpackage

// File: rtl/tfir_tap.sv
`timescale 1ns/1ps
// One broadcast tap: product of the shared sample and a fixed weight,
// added to the sum arriving from the far side, then registered.
module tfir_tap #(
   parameter int XW = 16,
   parameter int CW = 16,
   parameter int AW = 37,
   parameter logic [CW-1:0] COEF_VAL = '0
) (
   input  logic                 clk,
   input  logic                 arst,
   input  logic signed [XW-1:0] x_b,
   input  logic signed [AW-1:0] sum_in,
   output logic signed [AW-1:0] sum_q
);
   localparam int PW = XW + CW;
   localparam logic signed [CW-1:0] C_S = COEF_VAL;

   logic signed [PW-1:0] prod;
   assign prod = x_b * C_S;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) sum_q <= '0;
      else      sum_q <= AW'(prod) + sum_in;
   end
endmodule

// File: rtl/tfir_outstage.sv
`timescale 1ns/1ps
// Output tap: adds the b0 product, rounds half up, clamps or wraps, registers.
module tfir_outstage #(
   parameter int XW       = 16,
   parameter int CW       = 16,
   parameter int AW       = 37,
   parameter int YW       = 17,
   parameter int SHIFT    = 15,
   parameter bit SATURATE = 1'b1,
   parameter logic [CW-1:0] COEF_VAL = '0
) (
   input  logic                 clk,
   input  logic                 arst,
   input  logic signed [XW-1:0] x_b,
   input  logic signed [AW-1:0] chain_in,
   output logic        [YW-1:0] y_q
);
   localparam int PW = XW + CW;
   localparam logic signed [CW-1:0] C_S  = COEF_VAL;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SHIFT-1);
   localparam logic signed [AW-1:0] Y_HI = (AW'(1) <<< (YW-1)) - AW'(1);
   localparam logic signed [AW-1:0] Y_LO = -(AW'(1) <<< (YW-1));

   logic signed [PW-1:0] prod;
   logic signed [AW-1:0] total, scaled;
   logic        [YW-1:0] y_next;

   assign prod   = x_b * C_S;
   assign total  = AW'(prod) + chain_in;
   assign scaled = (total + HALF) >>> SHIFT;

   generate
      if (SATURATE) begin : g_clamp
         always_comb begin
            if (scaled > Y_HI)      y_next = Y_HI[YW-1:0];
            else if (scaled < Y_LO) y_next = Y_LO[YW-1:0];
            else                    y_next = scaled[YW-1:0];
         end
      end else begin : g_wrap
         assign y_next = scaled[YW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) y_q <= '0;
      else      y_q <= y_next;
   end
endmodule

// File: rtl/tfir_core.sv
`timescale 1ns/1ps
module tfir_core #(
   parameter int TAPS  = tfir_pkg::TAPS_DEF,
   parameter int XW    = 16,
   parameter int XF    = 15,
   parameter int CW    = tfir_pkg::CW_DEF,
   parameter int CF    = 15,
   parameter int YW    = 17,
   parameter int YF    = 15,
   parameter int GUARD = $clog2(TAPS),
   parameter bit SATURATE = 1'b1,
   parameter logic [TAPS*CW-1:0] COEF_VEC = tfir_pkg::default_coef_vec()
) (
   input  logic          clk,
   input  logic          arst,
   input  logic [XW-1:0] x_in,
   output logic [YW-1:0] y_out
);
   localparam int PW    = XW + CW;
   localparam int AW    = PW + GUARD;
   localparam int SHIFT = XF + CF - YF;

   generate
      if (TAPS < 2)               $error("tfir_core: TAPS must be at least 2");
      if (GUARD < $clog2(TAPS))   $error("tfir_core: GUARD too small for TAPS");
      if (SHIFT < 1)              $error("tfir_core: output keeps too many fraction bits");
      if (YW > AW - SHIFT)        $error("tfir_core: YW exceeds accumulator range");
   endgenerate

   logic signed [XW-1:0] x_q;
   logic signed [AW-1:0] chain [1:TAPS];

   always_ff @(posedge clk or posedge arst) begin
      if (arst) x_q <= '0;
      else      x_q <= signed'(x_in);
   end

   assign chain[TAPS] = '0;

   // Tap k holds the sum of b_k..b_{TAPS-1} terms; far end takes b_{TAPS-1}.
   generate
      for (genvar k = 1; k < TAPS; k++) begin : g_tap
         tfir_tap #(
            .XW(XW), .CW(CW), .AW(AW),
            .COEF_VAL(COEF_VEC[k*CW +: CW])
         ) u_tap (
            .clk(clk), .arst(arst), .x_b(x_q),
            .sum_in(chain[k+1]), .sum_q(chain[k])
         );
      end
   endgenerate

   tfir_outstage #(
      .XW(XW), .CW(CW), .AW(AW), .YW(YW), .SHIFT(SHIFT),
      .SATURATE(SATURATE), .COEF_VAL(COEF_VEC[CW-1:0])
   ) u_out (
      .clk(clk), .arst(arst), .x_b(x_q),
      .chain_in(chain[1]), .y_q(y_out)
   );
endmodule

// File: rtl/tfir_chk.sv
`timescale 1ns/1ps
module tfir_chk #(
   parameter int TAPS = 25,
   parameter int XW   = 16,
   parameter int XF   = 15,
   parameter int CW   = 16,
   parameter int CF   = 15,
   parameter int YW   = 17,
   parameter int YF   = 15,
   parameter logic [TAPS*CW-1:0] COEF_VEC = '0
) (
   input logic          clk,
   input logic          arst,
   input logic [XW-1:0] x_in,
   input logic [YW-1:0] y_out
);
   localparam int SH = XF + CF - YF;
   localparam int RW = $clog2(TAPS+2) + 1;
   localparam logic [RW-1:0] RUN_FULL = RW'(TAPS+1);

   function automatic longint wt(int k);
      logic signed [CW-1:0] t;
      t = COEF_VEC[k*CW +: CW];
      return longint'(t);
   endfunction

   function automatic logic [YW-1:0] fit(longint acc);
      longint r, hi;
      r  = (acc + (longint'(1) << (SH-1))) >>> SH;
      hi = (longint'(1) << (YW-1)) - 1;
      if (r > hi)        r = hi;
      else if (r < -hi-1) r = -hi-1;
      return YW'(r);
   endfunction

   function automatic logic [YW-1:0] dc_level(logic [XW-1:0] v);
      longint s;
      logic signed [XW-1:0] sv;
      sv = v;
      s = 0;
      for (int k = 0; k < TAPS; k++) s += wt(k);
      return fit(s * longint'(sv));
   endfunction

   function automatic logic [YW-1:0] first_term(logic [XW-1:0] v);
      logic signed [XW-1:0] sv;
      sv = v;
      return fit(wt(0) * longint'(sv));
   endfunction

   // Run of identical samples accepted; reset state counts as a long zero run.
   logic [XW-1:0] last_x;
   logic [RW-1:0] run;
   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         last_x <= '0;
         run    <= RUN_FULL;
      end else begin
         last_x <= x_in;
         if (x_in != last_x)    run <= RW'(1);
         else if (run < RUN_FULL) run <= run + RW'(1);
      end
   end

   assert_reset_zero_R1: assert property (@(posedge clk) arst |-> (y_out == '0));

   assert_quiet_zero_R1: assert property (@(posedge clk) disable iff (arst)
      (run >= RUN_FULL && last_x == '0) |-> (y_out == '0));

   assert_first_term_R2: assert property (@(posedge clk) disable iff (arst)
      (run >= RUN_FULL && last_x == '0) |=> ##1 (y_out == first_term($past(x_in, 2))));

   assert_dc_level_R8: assert property (@(posedge clk) disable iff (arst)
      (run >= RUN_FULL && $stable(x_in)) |-> (y_out == dc_level(last_x)));
endmodule

bind tfir_core tfir_chk #(
   .TAPS(TAPS), .XW(XW), .XF(XF), .CW(CW), .CF(CF),
   .YW(YW), .YF(YF), .COEF_VEC(COEF_VEC)
) u_chk (
   .clk(clk), .arst(arst), .x_in(x_in), .y_out(y_out)
);

// File: tb/sim_tfir_core.sv
`timescale 1ns/1ps
module sim_tfir_core;
   localparam int CLK_PERIOD = 20;
   localparam int NT = 25;

   logic        clk = 1'b0;
   logic        arst = 1'b1;
   logic [15:0] x_in = '0;
   logic [16:0] y_out;

   int n_chk = 0;
   int n_bad = 0;

   logic signed [15:0] win [NT];
   logic [16:0] exp_d1, exp_d2;
   string       tag_d1, tag_d2;

   localparam logic [15:0] VEC_TAB [32] = '{
      16'h0100, 16'h0000, 16'hFF00, 16'h1234, 16'h8001, 16'h7FFE, 16'h0003, 16'hFFFD,
      16'h4000, 16'hC000, 16'h2000, 16'hE000, 16'h0001, 16'hFFFF, 16'h5A5A, 16'hA5A5,
      16'h0000, 16'h0000, 16'h3FFF, 16'hC001, 16'h0800, 16'hF800, 16'h7000, 16'h9000,
      16'h0010, 16'hFFF0, 16'h1111, 16'hEEEE, 16'h0000, 16'h6000, 16'hA000, 16'h0002};

   tfir_core u0 (.clk(clk), .arst(arst), .x_in(x_in), .y_out(y_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   // Weight set stated in R3.
   function automatic longint wref(int k);
      longint m;
      m = (k <= 12) ? 2000*(k+1) : 2000*(25-k);
      return (k % 4 == 3) ? -m : m;
   endfunction

   function automatic logic [16:0] model();
      longint acc;
      acc = 0;
      for (int k = 0; k < NT; k++) acc += wref(k) * longint'(win[k]);
      acc = (acc + 16384) >>> 15;                 // R5
      if (acc > 65535)       acc = 65535;         // R6
      else if (acc < -65536) acc = -65536;
      return 17'(acc);
   endfunction

   task automatic check(input logic [16:0] exp, input string tag);
      n_chk++;
      if (y_out !== exp) begin
         n_bad++;
         $display("FAIL %s: y_out=%0d expected %0d", tag, $signed(y_out), $signed(exp));
      end
   endtask

   task automatic clear_model();
      for (int k = 0; k < NT; k++) win[k] = '0;
      exp_d1 = '0; exp_d2 = '0;
      tag_d1 = "R1"; tag_d2 = "R1";
   endtask

   // Output seen at this negedge belongs to the sample driven two negedges ago (R2).
   task automatic step(input logic [15:0] v, input string tag);
      @(negedge clk);
      check(exp_d2, tag_d2);
      exp_d2 = exp_d1; tag_d2 = tag_d1;
      for (int k = NT-1; k > 0; k--) win[k] = win[k-1];
      win[0] = v;
      x_in   = v;
      exp_d1 = model();
      tag_d1 = tag;
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      arst = 1'b1;
      x_in = 16'h7FFF;
      #1 check(17'd0, "R1");           // async clear, no edge yet
      repeat (3) @(negedge clk);
      check(17'd0, "R1");
      x_in = '0;
      arst = 1'b0;
      clear_model();
   endtask

   task automatic hold(input logic [15:0] v, input int n, input string tag);
      for (int i = 0; i < n; i++) step(v, tag);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      n_chk++; n_bad++;
      $display("FAIL R8: watchdog expired, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] lf;
      clear_model();
      pulse_reset();
      hold(16'h0000, 3, "R1");

      // table walk, mixed patterns
      for (int i = 0; i < 32; i++) step(VEC_TAB[i], "R4");
      hold(16'h0000, 27, "R4");

      // impulses: half scale, negative full scale, one LSB (rounding)
      step(16'h4000, "R3"); hold(16'h0000, 27, "R3");
      step(16'h8000, "R3"); hold(16'h0000, 27, "R3");
      step(16'h0001, "R5"); hold(16'h0000, 27, "R5");
      step(16'h0003, "R5"); hold(16'h0000, 27, "R5");

      // full-scale steps of both signs: clamp, no wrap
      hold(16'h7FFF, 30, "R6");
      hold(16'h8000, 30, "R7");
      hold(16'h0000, 28, "R6");

      // small steady level: unclamped constant
      hold(16'h0040, 30, "R8");
      hold(16'h0000, 28, "R8");

      // back-to-back pseudo-random samples
      lf = 16'hACE1;
      for (int i = 0; i < 160; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf, "R8");
      end

      // reset in mid-stream, then the response starts from zero
      pulse_reset();
      hold(16'h0000, 3, "R1");
      step(16'h2000, "R2"); hold(16'h0000, 28, "R2");

      summary();
      $finish;
   end
endmodule